// File: doc/BRIEF.md
# Configurable-Length Serial Bit Engine

This block is the master-side shifter of a serial link. It moves a frame of bits out on a serial data line while it drives the matching serial clock, and at the same time it captures one received bit per clock. Each frame is started by a one-cycle strobe that loads the transmit byte. The block supports two formats. In the two-wire bus format a frame holds a programmable number of data bits followed by one acknowledge bit. In the clocked synchronous format a frame holds eight data bits and no acknowledge bit. Timing comes from a transfer-clock enable pulse supplied by the surrounding logic. Each half of a serial clock period lasts one such pulse period.

A small control register sets the frame length code, the bit order and an optional stretch of the clock before the acknowledge bit. A write-protect qualifier guards the length code. While a frame runs, reading the register returns the number of bits still to move. The code clears itself when a frame ends and when a start condition is reported. Writes that would change the length at an unsafe moment are refused and recorded in a sticky flag.

Top module: `serial_bit_engine`

## Requirements
- R1: After reset, `regRdData` reads 0xE0 (bits 7..5 read 1, length code in bits 4..2 is 000, wait bit 1 and order bit 0 are 0), `sclOut` and `sdaOut` are 1, and `doneStb` and `wrErr` are 0.
- R2: In bus format (`busMode`=1), length code 000 gives 8 data bits plus an acknowledge bit (9 clock pulses), and code k from 1 to 7 gives k data bits plus an acknowledge bit (k+1 pulses). During the acknowledge pulse `sdaOut` is 1. A code written while idle with `sclOut` low reads back unchanged.
- R3: In synchronous format (`busMode`=0), every frame is 8 data pulses with no acknowledge bit, and a write to the length code is ignored.
- R4: With order bit (bit 0) at 0, transmit data leaves MSB first and each received bit enters at bit 0 while the shift register moves left. With the bit at 1, data leaves LSB first and each received bit enters at bit 7 while the register moves right. `rxData` is the shift register after the frame.
- R5: While a frame runs, bits 4..2 read the remaining bit count. In bus format they read (remaining minus 1) modulo 8. In synchronous format they read the remaining count modulo 8.
- R6: A write with bit 5 at 1 leaves the length code unchanged, and bit 5 always reads 1.
- R7: When the last bit of a frame ends, `doneStb` is high for exactly one cycle, the length code reads 000 from that cycle on, and in bus format `ackLevel` holds the `sdaIn` level sampled in the acknowledge pulse.
- R8: A `startDet` pulse aborts any frame, clears the length code to 000 and releases `sclOut` high on the next cycle, with no `doneStb`.
- R9: In bus format with the wait bit (bit 1) at 1, `sclOut` stays low for three transfer-clock periods before the acknowledge pulse instead of one. In synchronous format the wait bit has no effect.
- R10: A bus-format write with bit 5 at 0 and a nonzero length code is refused, and `wrErr` is set and stays set, when a frame is in progress or `sclOut` is high. While a frame runs, a write changes no field at all.
- R11: Each clock phase lasts one transfer-clock enable period. `sdaIn` is sampled on the rising `sclOut` edge, `sdaOut` changes only while `sclOut` is low, and `sclOut` rests low between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Transfer-clock enable, one cycle per phase |
| busMode | input | 1 | 1: two-wire bus format, 0: clocked synchronous format |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register read value |
| goStb | input | 1 | Starts a frame when idle |
| txData | input | 8 | Byte loaded at frame start |
| startDet | input | 1 | Start condition seen on the bus |
| sdaIn | input | 1 | Serial data in |
| sclOut | output | 1 | Serial clock out |
| sdaOut | output | 1 | Serial data out |
| rxData | output | 8 | Shift register contents |
| doneStb | output | 1 | One-cycle frame-end pulse |
| ackLevel | output | 1 | Sampled acknowledge level |
| wrErr | output | 1 | Sticky refused-write flag |

## Verification
The hardest states to reach are the refused writes and the abort. A refused write needs either a frame in flight or a released clock line, and the abort has to land in the middle of a frame. The bench writes a conflicting value once the second clock pulse of a long bus frame has been counted. It then lets that frame finish and compares the result with the values that were programmed before the write. Separately, it raises a start condition after two pulses of another frame. After the abort the clock line is high, so a nonzero write in that state exercises the second refusal path. Randomized frames across both formats, both orders, the wait option and every length code cover the stretched acknowledge pulse and the remaining-count readback.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } sbeState_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic load;      // capture transmit byte
    logic sample;    // rising clock: take sdaIn
    logic shift;     // falling clock after a data bit
    logic ackCap;    // falling clock after the acknowledge bit
    logic drive;     // a frame is active
    logic ackPhase;  // current bit is the acknowledge bit
    logic lsbFirst;  // order select
  } sbeCtl_t;

  localparam int REG_ORDER_BIT = 0;
  localparam int REG_WAIT_BIT  = 1;
  localparam int REG_CODE_LO   = 2;

endpackage

// File: rtl/sbe_dp.sv
module sbe_dp
  import sbe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbeCtl_t           ctl,
  input  logic [DATA_W-1:0] txData,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic [DATA_W-1:0] rxData,
  output logic              ackLevel
);

  logic [DATA_W-1:0] shReg;
  logic              rxBit;
  logic              ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      rxBit <= 1'b1;
      ackQ  <= 1'b1;
    end else begin
      if (ctl.load) begin
        shReg <= txData;
      end else if (ctl.shift) begin
        if (ctl.lsbFirst) shReg <= {rxBit, shReg[DATA_W-1:1]};
        else              shReg <= {shReg[DATA_W-2:0], rxBit};
      end
      if (ctl.sample) rxBit <= sdaIn;
      if (ctl.ackCap) ackQ  <= rxBit;
    end
  end

  always_comb begin
    if (!ctl.drive || ctl.ackPhase) sdaOut = 1'b1;
    else if (ctl.lsbFirst)          sdaOut = shReg[0];
    else                            sdaOut = shReg[DATA_W-1];
  end

  assign rxData   = shReg;
  assign ackLevel = ackQ;

endmodule

// File: rtl/sbe_ctrl.sv
module sbe_ctrl
  import sbe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int WAIT_TICKS = 2,
  localparam int CODE_W    = $clog2(DATA_W),
  localparam int REG_W     = CODE_W + 5,
  localparam int CNT_W     = $clog2(DATA_W + 2),
  localparam int WAIT_W    = $clog2(WAIT_TICKS + 1),
  localparam int WP_BIT    = REG_CODE_LO + CODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             busMode,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             goStb,
  input  logic             startDet,
  output logic [REG_W-1:0] regRdData,
  output logic             sclOut,
  output logic             doneStb,
  output logic             wrErr,
  output sbeCtl_t          ctl
);

  sbeState_t         state;
  logic [CODE_W-1:0] lenCode;
  logic              lsbFirst;
  logic              waitEn;
  logic [CNT_W-1:0]  bitsLeft;
  logic [WAIT_W-1:0] waitCnt;
  logic              busy;
  logic [CNT_W-1:0]  frameLen;
  logic [CNT_W-1:0]  rdCnt;
  logic [CODE_W-1:0] codeRd;
  logic [CODE_W-1:0] wrCode;
  logic              wrProt;
  logic              wrReject;
  logic              unusedWrTop;

  assign busy   = (state != ST_IDLE);
  assign wrCode = regWrData[REG_CODE_LO +: CODE_W];
  assign wrProt = regWrData[WP_BIT];
  assign unusedWrTop = ^regWrData[REG_W-1:WP_BIT+1];

  // bits per frame: data plus acknowledge in bus format
  always_comb begin
    if (!busMode)            frameLen = CNT_W'(DATA_W);
    else if (lenCode == '0)  frameLen = CNT_W'(DATA_W + 1);
    else                     frameLen = CNT_W'(lenCode) + CNT_W'(1);
  end

  assign wrReject = busMode && !wrProt && (wrCode != '0) && (busy || sclOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sclOut   <= 1'b1;
      lenCode  <= '0;
      lsbFirst <= 1'b0;
      waitEn   <= 1'b0;
      bitsLeft <= '0;
      waitCnt  <= '0;
      doneStb  <= 1'b0;
      wrErr    <= 1'b0;
    end else begin
      doneStb <= 1'b0;
      if (startDet) begin
        state   <= ST_IDLE;
        sclOut  <= 1'b1;
        lenCode <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (goStb) begin
              bitsLeft <= frameLen;
              sclOut   <= 1'b0;
              state    <= ST_LOW;
            end
          end
          ST_LOW: begin
            if (tick) begin
              sclOut <= 1'b1;
              state  <= ST_HIGH;
            end
          end
          ST_HIGH: begin
            if (tick) begin
              sclOut   <= 1'b0;
              bitsLeft <= bitsLeft - CNT_W'(1);
              if (bitsLeft == CNT_W'(1)) begin
                state   <= ST_IDLE;
                lenCode <= '0;
                doneStb <= 1'b1;
              end else if (busMode && waitEn && bitsLeft == CNT_W'(2)) begin
                state   <= ST_WAIT;
                waitCnt <= '0;
              end else begin
                state <= ST_LOW;
              end
            end
          end
          ST_WAIT: begin
            if (tick) begin
              if (waitCnt == WAIT_W'(WAIT_TICKS - 1)) state <= ST_LOW;
              else waitCnt <= waitCnt + WAIT_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase

        if (regWrEn) begin
          if (wrReject) begin
            wrErr <= 1'b1;
          end else if (!busy) begin
            lsbFirst <= regWrData[REG_ORDER_BIT];
            waitEn   <= regWrData[REG_WAIT_BIT];
            if (busMode && !wrProt) lenCode <= wrCode;
          end
        end
      end
    end
  end

  always_comb begin
    rdCnt  = busMode ? (bitsLeft - CNT_W'(1)) : bitsLeft;
    codeRd = busy ? rdCnt[CODE_W-1:0] : lenCode;
  end

  assign regRdData = {2'b11, 1'b1, codeRd, waitEn, lsbFirst};

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == ST_IDLE) && goStb && !startDet;
    ctl.sample   = (state == ST_LOW) && tick && !startDet;
    ctl.ackPhase = busy && busMode && (bitsLeft == CNT_W'(1));
    ctl.shift    = (state == ST_HIGH) && tick && !startDet && !ctl.ackPhase;
    ctl.ackCap   = (state == ST_HIGH) && tick && !startDet && ctl.ackPhase;
    ctl.drive    = busy;
    ctl.lsbFirst = lsbFirst;
  end

endmodule

// File: rtl/serial_bit_engine.sv
module serial_bit_engine
  import sbe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int WAIT_TICKS = 2,
  localparam int CODE_W    = $clog2(DATA_W),
  localparam int REG_W     = CODE_W + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busMode,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              goStb,
  input  logic [DATA_W-1:0] txData,
  input  logic              startDet,
  input  logic              sdaIn,
  output logic              sclOut,
  output logic              sdaOut,
  output logic [DATA_W-1:0] rxData,
  output logic              doneStb,
  output logic              ackLevel,
  output logic              wrErr
);

  sbeCtl_t ctl;

  sbe_ctrl #(
    .DATA_W    (DATA_W),
    .WAIT_TICKS(WAIT_TICKS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .busMode  (busMode),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .goStb    (goStb),
    .startDet (startDet),
    .regRdData(regRdData),
    .sclOut   (sclOut),
    .doneStb  (doneStb),
    .wrErr    (wrErr),
    .ctl      (ctl)
  );

  sbe_dp #(
    .DATA_W(DATA_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .txData  (txData),
    .sdaIn   (sdaIn),
    .sdaOut  (sdaOut),
    .rxData  (rxData),
    .ackLevel(ackLevel)
  );

endmodule

// File: rtl/serial_bit_engine_chk.sv
module serial_bit_engine_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              startDet,
  input logic [CODE_W-1:0] codeRd,
  input logic              sclOut,
  input logic              sdaOut,
  input logic              doneStb,
  input logic              wrErr
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb); // R7

  AST_DONE_CLEARS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (codeRd == '0)); // R7

  AST_DONE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> !sclOut); // R11

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (sclOut && codeRd == '0 && !doneStb)); // R8

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && !$past(startDet)) |-> $stable(sdaOut)); // R11

  AST_SCL_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclOut) && !$past(startDet)) |-> $past(tick)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrErr) |-> wrErr); // R10

endmodule

bind serial_bit_engine serial_bit_engine_chk #(.CODE_W(CODE_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .startDet(startDet),
  .codeRd  (regRdData[4:2]),
  .sclOut  (sclOut),
  .sdaOut  (sdaOut),
  .doneStb (doneStb),
  .wrErr   (wrErr)
);

// File: tb/test_serial_bit_engine.sv
module test_serial_bit_engine;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       busMode = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       goStb = 1'b0;
  logic [7:0] txData = '0;
  logic       startDet = 1'b0;
  logic       sdaIn;
  logic       sclOut, sdaOut, doneStb, ackLevel, wrErr;
  logic [7:0] rxData;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_bit_engine i_serial_bit_engine (
    .clk(clk), .rstN(rstN), .tick(tick), .busMode(busMode),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .goStb(goStb), .txData(txData), .startDet(startDet), .sdaIn(sdaIn),
    .sclOut(sclOut), .sdaOut(sdaOut), .rxData(rxData),
    .doneStb(doneStb), .ackLevel(ackLevel), .wrErr(wrErr)
  );

  // periodic transfer-clock enable
  int divCnt = 0;
  always @(negedge clk) begin
    divCnt = (divCnt == DIV - 1) ? 0 : divCnt + 1;
    tick = (divCnt == 0);
  end

  // line monitor
  logic        prevScl = 1'b1;
  int          pulseCnt = 0;
  int          lowCnt = 0;
  int          lastLow = 0;
  int          doneCnt = 0;
  int          midRd = -1;
  logic [15:0] sent = '0;
  logic [15:0] rxPat = '0;

  always_comb sdaIn = rxPat[4'(pulseCnt)];

  always @(negedge clk) begin
    if (sclOut && !prevScl) begin
      sent[4'(pulseCnt)] = sdaOut;
      lastLow = lowCnt;
      pulseCnt++;
    end
    if (!sclOut && prevScl && pulseCnt == 3) midRd = int'(regRdData[4:2]);
    lowCnt = sclOut ? 0 : lowCnt + 1;
    if (doneStb) doneCnt++;
    prevScl = sclOut;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [7:0] expRx(input logic [7:0] tx, input logic [15:0] pat,
                                       input int d, input bit lsb);
    logic [7:0] s = tx;
    for (int k = 0; k < d; k++) s = lsb ? {pat[k], s[7:1]} : {s[6:0], pat[k]};
    return s;
  endfunction

  task automatic runFrame(input bit bus, input logic [2:0] code, input bit lsb,
                          input bit wt, input logic [7:0] tx, input logic [15:0] pat,
                          input bit midWrite);
    int n, d, expLow, expMid;
    bit bitsOk, wrote;
    @(negedge clk);
    busMode = bus;
    wrReg({3'b000, code, wt, lsb});
    if (bus) chk(regRdData[4:2] == code, "R2", "length code readback", regRdData[4:2], code);
    else     chk(regRdData[4:2] == 3'b000, "R3", "sync count write ignored", regRdData[4:2], 0);
    rxPat = pat; pulseCnt = 0; doneCnt = 0; midRd = -1; sent = '0;
    @(negedge clk);
    goStb = 1'b1; txData = tx;
    @(negedge clk);
    goStb = 1'b0; txData = ~tx;
    wrote = 0;
    for (int t = 0; t < 3000 && doneCnt == 0; t++) begin
      if (midWrite && !wrote && pulseCnt == 2) begin
        wrote = 1;
        wrReg({3'b000, 3'b011, ~wt, ~lsb}); // refused: frame in flight (R10)
      end else begin
        @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
    n = bus ? ((code == 0) ? 9 : int'(code) + 1) : 8;
    d = bus ? n - 1 : 8;
    chk(pulseCnt == n, bus ? "R2" : "R3", "clock pulses per frame", pulseCnt, n);
    bitsOk = 1;
    for (int k = 0; k < d; k++) if (sent[k] != (lsb ? tx[k] : tx[7-k])) bitsOk = 0;
    chk(bitsOk, "R4", "transmit bit order", sent, tx);
    if (bus) chk(sent[d] == 1'b1, "R2", "ack pulse released", sent[d], 1);
    chk(rxData == expRx(tx, pat, d, lsb), "R4", "received data", rxData, expRx(tx, pat, d, lsb));
    if (bus) chk(ackLevel == pat[d], "R7", "ack level", ackLevel, pat[d]);
    chk(doneCnt == 1, "R7", "done pulse count", doneCnt, 1);
    chk(regRdData[4:2] == 3'b000, "R7", "code cleared after frame", regRdData[4:2], 0);
    expLow = (bus && wt) ? 3 * DIV : DIV;
    chk(lastLow == expLow, "R9", "low time before last pulse", lastLow, expLow);
    if (n > 3) begin
      expMid = bus ? ((n - 4) & 7) : ((8 - 3) & 7);
      chk(midRd == expMid, "R5", "remaining count readback", midRd, expMid);
    end
    chk(sclOut == 1'b0, "R11", "clock rests low between frames", sclOut, 0);
    if (midWrite) chk(wrErr == 1'b1, "R10", "busy write flagged", wrErr, 1);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0157);
    repeat (4) @(negedge clk);
    chk(regRdData == 8'hE0, "R1", "reset readback", regRdData, 8'hE0);
    chk(sclOut == 1'b1 && sdaOut == 1'b1, "R1", "idle lines in reset", {sclOut, sdaOut}, 3);
    chk(doneStb == 1'b0 && wrErr == 1'b0, "R1", "flags in reset", {doneStb, wrErr}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(regRdData == 8'hE0, "R1", "readback after reset", regRdData, 8'hE0);

    runFrame(0, 3'd0, 0, 0, 8'hA5, 16'h3C96, 0);
    chk(wrErr == 1'b0, "R10", "no error from legal writes", wrErr, 0);

    // write-protect qualifier
    busMode = 1'b1;
    wrReg(8'b0011_1000);
    chk(regRdData[4:2] == 3'b000, "R6", "protected write keeps code", regRdData[4:2], 0);
    chk(regRdData[5] == 1'b1, "R6", "protect bit reads one", regRdData[5], 1);
    chk(wrErr == 1'b0, "R6", "protected write not an error", wrErr, 0);

    // directed corners
    runFrame(1, 3'd0, 0, 0, 8'hC3, 16'h01A5, 0);
    runFrame(1, 3'd0, 1, 1, 8'h5A, 16'h0100, 0);
    runFrame(1, 3'd1, 0, 1, 8'h80, 16'h0002, 0);
    runFrame(1, 3'd7, 1, 0, 8'h1E, 16'h00F0, 0);
    runFrame(0, 3'd5, 1, 1, 8'h96, 16'h00C3, 0); // R9: wait ignored in sync

    for (int i = 0; i < 24; i++) begin
      runFrame(1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
               8'($urandom), 16'($urandom), 0);
    end

    // refused write during a frame
    runFrame(1, 3'd0, 0, 0, 8'h6B, 16'h0155, 1);

    // start condition abort
    busMode = 1'b1;
    wrReg(8'b0000_0000);
    pulseCnt = 0; doneCnt = 0; rxPat = '0;
    @(negedge clk); goStb = 1'b1; txData = 8'hFF;
    @(negedge clk); goStb = 1'b0;
    for (int t = 0; t < 500 && pulseCnt < 2; t++) @(negedge clk);
    startDet = 1'b1;
    @(negedge clk);
    startDet = 1'b0;
    chk(sclOut == 1'b1, "R8", "clock released on start", sclOut, 1);
    chk(regRdData[4:2] == 3'b000, "R8", "code cleared on start", regRdData[4:2], 0);
    repeat (60) @(negedge clk);
    chk(doneCnt == 0, "R8", "no done after abort", doneCnt, 0);
    chk(pulseCnt == 2, "R8", "no pulses after abort", pulseCnt, 2);

    // nonzero write with clock high is refused
    wrReg(8'b0001_0100);
    chk(regRdData[4:2] == 3'b000, "R10", "write with clock high refused", regRdData[4:2], 0);

    runFrame(0, 3'd0, 0, 0, 8'h3D, 16'h00AA, 0);
    runFrame(1, 3'd4, 0, 0, 8'hE7, 16'h0013, 0);

    summary();
  end

endmodule